// File: doc/BRIEF.md
# Self-timed program cycle controller

This block sits behind a serial command decoder and turns its one-cycle request strobes into timed nonvolatile program cycles. It owns the program-enable latch and accepts five requests: set the latch, clear the latch, program one word, erase the whole array and program the whole array. A one-word program erases the target word to all ones and then ANDs the new data into it. A whole-array erase sets every word to all ones. A whole-array program ANDs the data into every word and does not erase first.

Each cycle is timed by a down counter in system-clock ticks. The cycle lengths are parameters, set per operation and per word width, so they can be scaled from milliseconds down to a few ticks. The array itself is outside the block: a memory port issues one strobe per step, naming the step kind (set-to-ones or AND), one word or all words, the address and the data. While busy, `rdy_o` is low. Once a cycle has started it runs without any further strobe and finishes whatever the request inputs do. A power-good input that is low blocks all requests and abandons a running cycle.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset `rdy_o` is 1, `err_o` is 0, `mem_op_o` is 0 and the enable latch is clear.
- R2: While the enable latch is clear, the program, erase-all and program-all requests start no cycle and cause no memory strobe.
- R3: The set request (`ewen_i`) sets the latch and the clear request (`ewds_i`) clears it. Clear wins when both come together. Neither request makes `rdy_o` low.
- R4: A one-word program gives a set-to-ones strobe (`mem_op_o`=1, `mem_all_o`=0) at the latched address in busy cycle ERASE8 or ERASE16. It then gives an AND strobe (`mem_op_o`=2) with the data in busy cycle T_WR8 or T_WR16. Which pair applies depends on `org16_i` at the request.
- R5: An erase-all gives one set-to-ones strobe with `mem_all_o`=1 in busy cycle T_ERAL.
- R6: A program-all gives one AND strobe with `mem_all_o`=1 in busy cycle T_WRAL and no erase step.
- R7: `rdy_o` is low for exactly the cycle length of the running operation, starting in the cycle after the accepted request. It is high otherwise, and memory strobes appear only while it is low.
- R8: A request that arrives while busy is dropped and does not change the cycle's timing or result. It sets `err_o`, which stays set until reset.
- R9: While `pwr_ok_i` is 0, requests are ignored. A running cycle is abandoned with no further memory strobe, and `rdy_o` is high from the next cycle.
- R10: In 8-bit mode (`org16_i`=0) only `data_i[7:0]` is used and the upper byte of `mem_wdata_o` is all ones. In 16-bit mode the top address bit is driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply good; low inhibits everything |
| org16_i | input | 1 | 1: 16-bit words, 0: 8-bit words |
| ewen_i | input | 1 | Set enable latch strobe |
| ewds_i | input | 1 | Clear enable latch strobe |
| write_i | input | 1 | One-word program strobe |
| eral_i | input | 1 | Erase-all strobe |
| wral_i | input | 1 | Program-all strobe |
| addr_i | input | AW | Word address |
| data_i | input | DW | Program data |
| rdy_o | output | 1 | High when idle, low while a cycle runs |
| err_o | output | 1 | Sticky flag: request dropped while busy |
| mem_op_o | output | 2 | 0 none, 1 set word(s) to ones, 2 AND data into word(s) |
| mem_all_o | output | 1 | Strobe applies to every word |
| mem_addr_o | output | AW | Strobe address |
| mem_wdata_o | output | DW | Strobe data |

## Verification
The bench counts busy cycles from the clock edge that takes a request. `rdy_o` must fall in cycle 1 and rise right after cycle T. The erase strobe of a one-word program is due in cycle E and the final strobe in cycle T, and the bench's memory model takes each one at the following edge. Every signal is sampled on falling edges, and each strobe is logged with its cycle index, so each is checked against the arithmetic E and T for its operation and width. The whole memory model is then compared word by word with an expected image built from the set-then-AND and AND rules.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {MOP_NONE = 2'd0, MOP_SET = 2'd1, MOP_AND = 2'd2} mem_op_e;
  typedef enum logic [1:0] {K_WORD, K_ERALL, K_PRALL} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG} state_e;
endpackage

// File: rtl/pcc_guard.sv
module pcc_guard
  import pcc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwr_ok_i,
  input  logic  busy_i,
  input  logic  ewen_i,
  input  logic  ewds_i,
  input  logic  write_i,
  input  logic  eral_i,
  input  logic  wral_i,
  output logic  en_o,
  output logic  start_o,
  output kind_e kind_o,
  output logic  err_o
);
  logic en_q, err_q, any_req, any_op;

  assign any_req = ewen_i | ewds_i | write_i | eral_i | wral_i;
  assign any_op  = write_i | eral_i | wral_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (pwr_ok_i) begin
      if (busy_i) begin
        if (any_req) err_q <= 1'b1;
      end else if (ewds_i) begin
        en_q <= 1'b0;
      end else if (ewen_i) begin
        en_q <= 1'b1;
      end
    end
  end

  // latch commands take precedence over any operation in the same cycle
  assign start_o = pwr_ok_i && !busy_i && en_q && !ewen_i && !ewds_i && any_op;

  always_comb begin
    if (eral_i)      kind_o = K_ERALL;
    else if (wral_i) kind_o = K_PRALL;
    else             kind_o = K_WORD;
  end

  assign en_o  = en_q;
  assign err_o = err_q;
endmodule

// File: rtl/pcc_timer.sv
module pcc_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
  import pcc_pkg::*;
#(
  parameter int AW      = 7,
  parameter int DW      = 16,
  parameter int T_WR8   = 1000,
  parameter int T_WR16  = 2000,
  parameter int T_ERAL  = 15000,
  parameter int T_WRAL  = 15000,
  parameter int ERASE8  = T_WR8 / 2,
  parameter int ERASE16 = T_WR16 / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_ok_i,
  input  logic          org16_i,
  input  logic          ewen_i,
  input  logic          ewds_i,
  input  logic          write_i,
  input  logic          eral_i,
  input  logic          wral_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rdy_o,
  output logic          err_o,
  output logic [1:0]    mem_op_o,
  output logic          mem_all_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int M1   = (T_WR8 > T_WR16) ? T_WR8 : T_WR16;
  localparam int M2   = (T_ERAL > T_WRAL) ? T_ERAL : T_WRAL;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int NW   = DW / 2;

  localparam logic [TW-1:0] L_E8   = TW'(ERASE8 - 1);
  localparam logic [TW-1:0] L_E16  = TW'(ERASE16 - 1);
  localparam logic [TW-1:0] L_P8   = TW'(T_WR8 - ERASE8 - 1);
  localparam logic [TW-1:0] L_P16  = TW'(T_WR16 - ERASE16 - 1);
  localparam logic [TW-1:0] L_ERAL = TW'(T_ERAL - 1);
  localparam logic [TW-1:0] L_WRAL = TW'(T_WRAL - 1);

  state_e        state_q;
  kind_e         kind_q, req_kind;
  logic          org_q, wr_en, start, busy, zero, load;
  logic [TW-1:0] load_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  mem_op_e       op;

  assign busy = (state_q != S_IDLE);

  pcc_guard u_guard (
    .clk_i, .rst_ni, .pwr_ok_i,
    .busy_i  (busy),
    .ewen_i, .ewds_i, .write_i, .eral_i, .wral_i,
    .en_o    (wr_en),
    .start_o (start),
    .kind_o  (req_kind),
    .err_o   (err_o)
  );

  pcc_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni,
    .load_i (load),
    .val_i  (load_val),
    .zero_o (zero)
  );

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (state_q == S_IDLE && start) begin
      load = 1'b1;
      unique case (req_kind)
        K_ERALL: load_val = L_ERAL;
        K_PRALL: load_val = L_WRAL;
        default: load_val = org16_i ? L_E16 : L_E8;
      endcase
    end else if (state_q == S_ERASE && zero) begin
      load     = 1'b1;
      load_val = org_q ? L_P16 : L_P8;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_WORD;
      org_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!pwr_ok_i) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          kind_q  <= req_kind;
          org_q   <= org16_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
          state_q <= (req_kind == K_WORD) ? S_ERASE : S_PROG;
        end
        S_ERASE: if (zero) state_q <= S_PROG;
        S_PROG:  if (zero) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    op = MOP_NONE;
    if (pwr_ok_i && zero) begin
      if (state_q == S_ERASE)                           op = MOP_SET;
      else if (state_q == S_PROG)                       op = (kind_q == K_ERALL) ? MOP_SET : MOP_AND;
    end
  end

  assign mem_op_o   = op;
  assign mem_all_o  = (kind_q != K_WORD);
  assign mem_addr_o = org_q ? {1'b0, addr_q[AW-2:0]} : addr_q;

  always_comb begin
    if (op == MOP_SET)  mem_wdata_o = '1;
    else if (org_q)     mem_wdata_o = data_q;
    else                mem_wdata_o = {{(DW-NW){1'b1}}, data_q[NW-1:0]};
  end

  assign rdy_o = !busy;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_ok_i,
  input logic       req_i,
  input logic       rdy_i,
  input logic       err_i,
  input logic [1:0] mem_op_i,
  input logic       en_i
);
  assert_locked_no_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i && !en_i) |=> rdy_i);

  assert_strobe_only_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_op_i != 2'd0) |-> !rdy_i);

  assert_ready_after_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_i) |-> $past(mem_op_i != 2'd0 || !pwr_ok_i));

  assert_busy_req_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_i && pwr_ok_i && req_i) |=> err_i);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  assert_power_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> rdy_i);
endmodule

bind prog_cycle_ctrl pcc_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwr_ok_i (pwr_ok_i),
  .req_i    (ewen_i | ewds_i | write_i | eral_i | wral_i),
  .rdy_i    (rdy_o),
  .err_i    (err_o),
  .mem_op_i (mem_op_o),
  .en_i     (wr_en)
);

// File: tb/test_prog_cycle_ctrl.sv
`timescale 1ns/1ps
module test_prog_cycle_ctrl;
  localparam int AW = 7, DW = 16, NWD = 128;
  localparam int T8 = 6, E8 = 3, T16 = 10, E16 = 5, TER = 20, TWA = 16;

  logic clk = 1'b0, rst_ni = 1'b0, pwr_ok = 1'b1, org16 = 1'b1;
  logic ewen = 0, ewds = 0, wr = 0, eral = 0, wral = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic rdy, err, mall;
  logic [1:0] mop;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwd;

  int n_run = 0, n_fail = 0, cyc_total = 0;
  logic [DW-1:0] mem [NWD];
  logic [DW-1:0] expm [NWD];
  int strobe_cyc [4];
  int strobe_op [4];
  int n_strobe;

  always #10 clk = ~clk;

  prog_cycle_ctrl #(.AW(AW), .DW(DW), .T_WR8(T8), .T_WR16(T16), .T_ERAL(TER),
                    .T_WRAL(TWA), .ERASE8(E8), .ERASE16(E16)) i_prog_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok), .org16_i(org16),
    .ewen_i(ewen), .ewds_i(ewds), .write_i(wr), .eral_i(eral), .wral_i(wral),
    .addr_i(addr), .data_i(data), .rdy_o(rdy), .err_o(err), .mem_op_o(mop),
    .mem_all_o(mall), .mem_addr_o(maddr), .mem_wdata_o(mwd));

  // memory model fed by the strobe port
  always @(posedge clk) begin
    if (mop == 2'd1) begin
      if (mall) for (int i = 0; i < NWD; i++) mem[i] <= '1;
      else mem[maddr] <= '1;
    end else if (mop == 2'd2) begin
      if (mall) for (int i = 0; i < NWD; i++) mem[i] <= mem[i] & mwd;
      else mem[maddr] <= mem[maddr] & mwd;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
      finish_run();
    end
  end

  // kind: 0 word, 1 erase-all, 2 program-all, 3 ewen, 4 ewds
  task automatic pulse(input int kind, input int a, input int d);
    @(negedge clk);
    addr = AW'(a); data = DW'(d);
    wr = (kind == 0); eral = (kind == 1); wral = (kind == 2);
    ewen = (kind == 3); ewds = (kind == 4);
    @(negedge clk);
    wr = 0; eral = 0; wral = 0; ewen = 0; ewds = 0;
  endtask

  // returns busy length; logs strobes by busy-cycle index
  task automatic watch(output int len);
    int c = 1;
    n_strobe = 0;
    while (!rdy && c < 1000) begin
      if (mop != 2'd0 && n_strobe < 4) begin
        strobe_cyc[n_strobe] = c; strobe_op[n_strobe] = int'(mop); n_strobe++;
      end
      @(negedge clk);
      c++;
    end
    len = c - 1;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, fa = 0;
    for (int i = 0; i < NWD; i++) if (mem[i] !== expm[i]) begin
      if (bad == 0) fa = i;
      bad++;
    end
    chk(bad == 0, req, (bad == 0) ? 0 : int'(mem[fa]), (bad == 0) ? 0 : int'(expm[fa]));
  endtask

  task automatic do_word(input int a, input int d, input bit o16);
    int len, ea, te, tt;
    org16 = o16;
    pulse(0, a, d);
    watch(len);
    te = o16 ? E16 : E8; tt = o16 ? T16 : T8;
    ea = o16 ? (a % 64) : (a % 128);
    chk(len == tt, "R7 word busy length", len, tt);
    chk(n_strobe == 2 && strobe_cyc[0] == te && strobe_op[0] == 1,
        "R4 erase step", strobe_cyc[0], te);
    chk(n_strobe == 2 && strobe_cyc[1] == tt && strobe_op[1] == 2,
        "R4 program step", strobe_cyc[1], tt);
    expm[ea] = o16 ? DW'(d) : {8'hFF, 8'(d)};
  endtask

  initial begin
    int len;
    for (int i = 0; i < NWD; i++) begin mem[i] = '0; expm[i] = '0; end
    repeat (3) @(negedge clk);
    chk(rdy === 1'b1 && err === 1'b0 && mop === 2'd0, "R1 reset outputs", {rdy, err, mop}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: locked after reset
    pulse(0, 5, 16'h1234);
    chk(rdy === 1'b1, "R2 write locked", rdy, 1);
    pulse(1, 0, 0);
    chk(rdy === 1'b1, "R2 erase-all locked", rdy, 1);
    pulse(2, 0, 0);
    repeat (3) @(negedge clk);
    chk(rdy === 1'b1, "R2 program-all locked", rdy, 1);
    cmp_mem("R2 memory untouched");

    // R3: enable, no busy
    pulse(3, 0, 0);
    chk(rdy === 1'b1, "R3 enable no busy", rdy, 1);

    // R5 erase-all
    pulse(1, 0, 0);
    watch(len);
    chk(len == TER, "R5 erase-all length", len, TER);
    chk(n_strobe == 1 && strobe_cyc[0] == TER && strobe_op[0] == 1, "R5 erase-all strobe", strobe_cyc[0], TER);
    for (int i = 0; i < NWD; i++) expm[i] = '1;
    cmp_mem("R5 all ones");

    // R4 sweep, 16-bit organisation
    for (int a = 0; a < 64; a++) do_word(a, (a * 16'h1357) ^ 16'hA5C3, 1'b1);
    cmp_mem("R4 16-bit sweep");

    // R10 8-bit organisation over every address
    for (int a = 0; a < 128; a++) do_word(a, (a * 37) ^ 16'h5A00, 1'b0);
    cmp_mem("R10 8-bit sweep upper byte ones");

    // R10 top address bit ignored in 16-bit mode
    do_word(64 + 9, 16'hBEEF, 1'b1);
    cmp_mem("R10 16-bit address wrap");

    // R6 program-all, no erase
    org16 = 1'b1;
    pulse(2, 0, 16'hF0F3);
    watch(len);
    chk(len == TWA, "R6 program-all length", len, TWA);
    chk(n_strobe == 1 && strobe_cyc[0] == TWA && strobe_op[0] == 2, "R6 single AND strobe", strobe_cyc[0], TWA);
    for (int i = 0; i < NWD; i++) expm[i] = expm[i] & 16'hF0F3;
    cmp_mem("R6 cell AND data");

    // R3 disable blocks, clear wins over set
    pulse(4, 0, 0);
    pulse(0, 3, 16'h0000);
    repeat (2) @(negedge clk);
    chk(rdy === 1'b1, "R3 disabled write ignored", rdy, 1);
    @(negedge clk); ewen = 1; ewds = 1; @(negedge clk); ewen = 0; ewds = 0;
    pulse(0, 3, 16'h0000);
    repeat (2) @(negedge clk);
    chk(rdy === 1'b1, "R3 clear wins", rdy, 1);
    cmp_mem("R3 memory unchanged");

    // R8 request while busy
    pulse(3, 0, 0);
    chk(err === 1'b0, "R8 err clear before", err, 0);
    pulse(1, 0, 0);
    repeat (4) @(negedge clk);
    wr = 1; addr = 7'd2; data = 16'h0000; @(negedge clk); wr = 0;
    watch(len);
    chk(len == TER - 5, "R8 timing unchanged", len, TER - 5);
    chk(err === 1'b1, "R8 err set", err, 1);
    for (int i = 0; i < NWD; i++) expm[i] = '1;
    cmp_mem("R8 dropped write no effect");
    repeat (3) @(negedge clk);
    chk(err === 1'b1, "R8 err sticky", err, 1);

    // R9 power loss mid-cycle
    pulse(2, 0, 16'h0000);
    repeat (5) @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk(rdy === 1'b1, "R9 abort ready", rdy, 1);
    pulse(1, 0, 0);
    chk(rdy === 1'b1, "R9 request ignored", rdy, 1);
    pwr_ok = 1'b1;
    repeat (TWA + 2) @(negedge clk);
    chk(rdy === 1'b1 && mop === 2'd0, "R9 no late strobe", rdy, 1);
    cmp_mem("R9 memory unchanged");

    finish_run();
  end
endmodule